// File: doc/BRIEF.md
# Chained CAM Cycle Acceptance Selector

This block sits beside one content-addressable memory in a daisy chain of such memories. It decides whether that device takes part in each bus cycle. A cycle is one of four kinds: command write, command read, data write or data read. The decision draws on several inputs:

- a 16-bit select value, compared with the device's own page address;
- the state of the match chain: the local compare enable, the local match, the match-in from higher-priority devices, and a control bit that enables the match flag;
- the full chain, made up of full-in and the device's own full flag.

A small set of instructions ignores the normal rules. Loading the select value reaches every device. Loading a page address, or setting the full flag, reaches only the first device that still has free space. A command read that follows a next-free status instruction is also answered only by that first device. To support this last rule, the block keeps the opcode of the last command write it accepted. The decision for a cycle appears on four registered accept outputs one clock after the cycle is sampled. At most one of them is high, and it is the one that matches the cycle kind.

Top module: `cam_chain_select`

## Requirements
- R1: Asynchronous reset (rst_ni low) drives all four accept outputs low and clears the stored last opcode to 0x00, so a command read after reset follows the normal rules.
- R2: An accept output rises only in the clock after a cycle with cyc_vld_i high. The output that rises is the one for cyc_kind_i, encoded 0 = command write, 1 = command read, 2 = data write, 3 = data read. A clock without a valid cycle leaves all outputs low.
- R3: With cmp_en_ni high and a select value of 0xFFFF, command cycles are accepted and data cycles are refused. This holds even when the page address is also 0xFFFF.
- R4: With cmp_en_ni high and a select value equal to the page address (and not 0xFFFF), all four cycle kinds are accepted.
- R5: With cmp_en_ni high and a select value that is neither 0xFFFF nor the page address, no cycle kind is accepted.
- R6: With cmp_en_ni low, match_flag_en_i high, match_act_ni low and match_in_ni high, all four cycle kinds are accepted.
- R7: With cmp_en_ni low and either match_act_ni high or match_in_ni low, command cycles are accepted and data cycles are refused.
- R8: With cmp_en_ni low and match_flag_en_i low, match_act_ni has no effect: command cycles are accepted and data cycles are refused.
- R9: A command write with opcode 0x01 (load select value) is accepted whatever the select value and the chain state are.
- R10: A command write with opcode 0x02 (load page address) or 0x03 (set full flag) is accepted only when full_in_ni is low and full_flag_ni is high.
- R11: After an accepted command write with opcode 0x04 (next-free status), each later command read is accepted only when full_in_ni is low and full_flag_ni is high. This lasts until another command write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_vld_i | input | 1 | A bus cycle is present this clock |
| cyc_kind_i | input | 2 | Cycle kind: 0 cmd write, 1 cmd read, 2 data write, 3 data read |
| cmd_op_i | input | 8 | Opcode carried by a command write |
| dev_sel_i | input | 16 | Current device-select value |
| page_addr_i | input | 16 | This device's page address |
| cmp_en_ni | input | 1 | Internal compare enable, active low |
| match_act_ni | input | 1 | Internal match active, active low |
| match_in_ni | input | 1 | Match-in from higher-priority devices, active low |
| full_in_ni | input | 1 | Full-in from the previous device, active low |
| full_flag_ni | input | 1 | This device's full flag, active low |
| match_flag_en_i | input | 1 | Match flag enable control bit |
| acc_cmd_wr_o | output | 1 | Command write accepted (registered) |
| acc_cmd_rd_o | output | 1 | Command read accepted (registered) |
| acc_dat_wr_o | output | 1 | Data write accepted (registered) |
| acc_dat_rd_o | output | 1 | Data read accepted (registered) |

## Verification
The bench covers several corner cases:
- A page address of 0xFFFF. If equality were checked before broadcast, data cycles would be accepted on that device.
- A disabled match flag together with an active local match. A design that ignored the enable would accept data cycles.
- Load-page and set-full writes aimed at devices that are full, or whose predecessor is not full. A design that fell back on the page compare would accept them on the wrong device.
- The next-free status history. The bench checks that the history arms only on an accepted write, that a later command write clears it, and that reset clears it. A design that kept stale history would refuse ordinary command reads after reset.

// File: rtl/cam_sel_pkg.sv
package cam_sel_pkg;
  localparam int unsigned OP_W = 8;
  localparam int unsigned KIND_N = 4;

  typedef enum logic [1:0] {
    CYC_CMD_WR = 2'd0,
    CYC_CMD_RD = 2'd1,
    CYC_DAT_WR = 2'd2,
    CYC_DAT_RD = 2'd3
  } cyc_kind_e;

  localparam logic [OP_W-1:0] OP_NOP       = 8'h00;
  localparam logic [OP_W-1:0] OP_LD_SEL    = 8'h01;
  localparam logic [OP_W-1:0] OP_LD_PAGE   = 8'h02;
  localparam logic [OP_W-1:0] OP_SET_FULL  = 8'h03;
  localparam logic [OP_W-1:0] OP_STAT_NF   = 8'h04;

  typedef struct packed {
    logic cmp_en_n;
    logic match_act_n;
    logic match_in_n;
    logic mflag_en;
  } chain_st_t;
endpackage

// File: rtl/cam_sel_decode.sv
module cam_sel_decode
  import cam_sel_pkg::*;
#(
  parameter int unsigned SEL_W = 16
) (
  input  logic [SEL_W-1:0]  dev_sel_i,
  input  logic [SEL_W-1:0]  page_addr_i,
  input  chain_st_t         st_i,
  output logic [KIND_N-1:0] base_acc_o
);
  logic bcast, page_hit, ma_n_eff, prio_hit;
  logic cmd_ok, dat_ok;

  assign bcast    = &dev_sel_i;
  assign page_hit = (dev_sel_i == page_addr_i);
  // disabled match flag masks the local match
  assign ma_n_eff = st_i.match_act_n | ~st_i.mflag_en;
  assign prio_hit = ~ma_n_eff & st_i.match_in_n;

  always_comb begin
    if (st_i.cmp_en_n) begin
      cmd_ok = bcast | page_hit;
      dat_ok = ~bcast & page_hit;
    end else begin
      cmd_ok = 1'b1;
      dat_ok = prio_hit;
    end
  end

  assign base_acc_o = {dat_ok, dat_ok, cmd_ok, cmd_ok};
endmodule

// File: rtl/cam_sel_history.sv
module cam_sel_history
  import cam_sel_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rec_i,
  input  logic [OP_W-1:0] op_i,
  output logic            after_nf_o
);
  logic [OP_W-1:0] last_op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    last_op_q <= OP_NOP;
    else if (rec_i) last_op_q <= op_i;
  end

  assign after_nf_o = (last_op_q == OP_STAT_NF);
endmodule

// File: rtl/cam_sel_override.sv
module cam_sel_override
  import cam_sel_pkg::*;
(
  input  logic [1:0]        kind_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic              after_nf_i,
  input  logic              first_empty_i,
  input  logic [KIND_N-1:0] base_acc_i,
  output logic [KIND_N-1:0] acc_o
);
  logic [KIND_N-1:0] kind_sel;
  logic              force_all, need_empty, acc_bit;

  for (genvar k = 0; k < KIND_N; k++) begin : g_kind
    assign kind_sel[k] = (kind_i == 2'(k));
  end

  assign force_all  = kind_sel[CYC_CMD_WR] & (op_i == OP_LD_SEL);
  assign need_empty = (kind_sel[CYC_CMD_WR] & ((op_i == OP_LD_PAGE) | (op_i == OP_SET_FULL)))
                    | (kind_sel[CYC_CMD_RD] & after_nf_i);

  always_comb begin
    if (force_all)       acc_bit = 1'b1;
    else if (need_empty) acc_bit = first_empty_i;
    else                 acc_bit = |(base_acc_i & kind_sel);
  end

  assign acc_o = kind_sel & {KIND_N{acc_bit}};
endmodule

// File: rtl/cam_chain_select.sv
module cam_chain_select
  import cam_sel_pkg::*;
#(
  parameter int unsigned SEL_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cyc_vld_i,
  input  logic [1:0]       cyc_kind_i,
  input  logic [OP_W-1:0]  cmd_op_i,
  input  logic [SEL_W-1:0] dev_sel_i,
  input  logic [SEL_W-1:0] page_addr_i,
  input  logic             cmp_en_ni,
  input  logic             match_act_ni,
  input  logic             match_in_ni,
  input  logic             full_in_ni,
  input  logic             full_flag_ni,
  input  logic             match_flag_en_i,
  output logic             acc_cmd_wr_o,
  output logic             acc_cmd_rd_o,
  output logic             acc_dat_wr_o,
  output logic             acc_dat_rd_o
);
  chain_st_t         st;
  logic [KIND_N-1:0] base_acc, ovr_acc, acc_d, acc_q;
  logic              first_empty, after_nf, rec;

  assign st = '{cmp_en_n: cmp_en_ni, match_act_n: match_act_ni,
                match_in_n: match_in_ni, mflag_en: match_flag_en_i};
  assign first_empty = ~full_in_ni & full_flag_ni;

  cam_sel_decode #(.SEL_W(SEL_W)) u_decode (
    .dev_sel_i  (dev_sel_i),
    .page_addr_i(page_addr_i),
    .st_i       (st),
    .base_acc_o (base_acc)
  );

  cam_sel_override u_override (
    .kind_i       (cyc_kind_i),
    .op_i         (cmd_op_i),
    .after_nf_i   (after_nf),
    .first_empty_i(first_empty),
    .base_acc_i   (base_acc),
    .acc_o        (ovr_acc)
  );

  assign acc_d = cyc_vld_i ? ovr_acc : '0;
  // only accepted command writes enter the history
  assign rec   = acc_d[CYC_CMD_WR];

  cam_sel_history u_history (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rec_i     (rec),
    .op_i      (cmd_op_i),
    .after_nf_o(after_nf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign acc_cmd_wr_o = acc_q[CYC_CMD_WR];
  assign acc_cmd_rd_o = acc_q[CYC_CMD_RD];
  assign acc_dat_wr_o = acc_q[CYC_DAT_WR];
  assign acc_dat_rd_o = acc_q[CYC_DAT_RD];
endmodule

// File: rtl/cam_chain_select_chk.sv
module cam_chain_select_chk
  import cam_sel_pkg::*;
#(
  parameter int unsigned SEL_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cyc_vld_i,
  input logic [1:0]       cyc_kind_i,
  input logic [OP_W-1:0]  cmd_op_i,
  input logic [SEL_W-1:0] dev_sel_i,
  input logic [SEL_W-1:0] page_addr_i,
  input logic             cmp_en_ni,
  input logic             match_act_ni,
  input logic             match_in_ni,
  input logic             full_in_ni,
  input logic             full_flag_ni,
  input logic             match_flag_en_i,
  input logic             acc_cmd_wr_o,
  input logic             acc_cmd_rd_o,
  input logic             acc_dat_wr_o,
  input logic             acc_dat_rd_o
);
  logic is_dat, first_empty, is_bcast;
  assign is_dat      = cyc_kind_i[1];
  assign first_empty = !full_in_ni && full_flag_ni;
  assign is_bcast    = &dev_sel_i;

  AST_ONE_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({acc_cmd_wr_o, acc_cmd_rd_o, acc_dat_wr_o, acc_dat_rd_o})); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_vld_i |=> !(acc_cmd_wr_o || acc_cmd_rd_o || acc_dat_wr_o || acc_dat_rd_o)); // R2

  AST_BCAST_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_vld_i && cmp_en_ni && is_bcast && is_dat |=> !(acc_dat_wr_o || acc_dat_rd_o)); // R3

  AST_PAGE_DATA_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_vld_i && cmp_en_ni && !is_bcast && (dev_sel_i == page_addr_i)
    && (cyc_kind_i == CYC_DAT_RD) |=> acc_dat_rd_o); // R4

  AST_MFLAG_OFF_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_vld_i && !cmp_en_ni && !match_flag_en_i && is_dat |=> !(acc_dat_wr_o || acc_dat_rd_o)); // R8

  AST_LD_SEL_ALWAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_vld_i && (cyc_kind_i == CYC_CMD_WR) && (cmd_op_i == OP_LD_SEL) |=> acc_cmd_wr_o); // R9

  AST_FIRST_EMPTY_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_vld_i && (cyc_kind_i == CYC_CMD_WR) && !first_empty
    && ((cmd_op_i == OP_LD_PAGE) || (cmd_op_i == OP_SET_FULL)) |=> !acc_cmd_wr_o); // R10

  AST_PRIO_MATCH_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_vld_i && !cmp_en_ni && match_flag_en_i && !match_act_ni && match_in_ni
    && (cyc_kind_i == CYC_DAT_WR) |=> acc_dat_wr_o); // R6
endmodule

bind cam_chain_select cam_chain_select_chk #(.SEL_W(SEL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cyc_vld_i(cyc_vld_i), .cyc_kind_i(cyc_kind_i),
  .cmd_op_i(cmd_op_i), .dev_sel_i(dev_sel_i), .page_addr_i(page_addr_i),
  .cmp_en_ni(cmp_en_ni), .match_act_ni(match_act_ni), .match_in_ni(match_in_ni),
  .full_in_ni(full_in_ni), .full_flag_ni(full_flag_ni), .match_flag_en_i(match_flag_en_i),
  .acc_cmd_wr_o(acc_cmd_wr_o), .acc_cmd_rd_o(acc_cmd_rd_o),
  .acc_dat_wr_o(acc_dat_wr_o), .acc_dat_rd_o(acc_dat_rd_o)
);

// File: tb/cam_chain_select_tb_top.sv
module cam_chain_select_tb_top;
  import cam_sel_pkg::*;
  localparam int SW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, vld, cmpn, man, minn, finn, ffn, men;
  logic [1:0]    kind;
  logic [OP_W-1:0] op;
  logic [SW-1:0] dsel, page;
  logic acc_cw, acc_cr, acc_dw, acc_dr;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  int model_last = 0;

  cam_chain_select #(.SEL_W(SW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cyc_vld_i(vld), .cyc_kind_i(kind), .cmd_op_i(op),
    .dev_sel_i(dsel), .page_addr_i(page), .cmp_en_ni(cmpn), .match_act_ni(man),
    .match_in_ni(minn), .full_in_ni(finn), .full_flag_ni(ffn), .match_flag_en_i(men),
    .acc_cmd_wr_o(acc_cw), .acc_cmd_rd_o(acc_cr), .acc_dat_wr_o(acc_dw), .acc_dat_rd_o(acc_dr)
  );

  task automatic check(input int tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {acc_dr, acc_dw, acc_cr, acc_cw};
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d act=%b exp=%b", tag, act, exp);
    end
  endtask

  // behavioural reference: pick the governing rule, then the verdict
  task automatic step();
    int tag;
    bit a, fe, cmd;
    logic [3:0] exp;
    fe  = !finn && ffn;
    cmd = (kind < 2);
    if (!vld) begin tag = 2; a = 0; end                                  // R2
    else if (kind == 0 && op == 8'h01) begin tag = 9; a = 1; end         // R9
    else if (kind == 0 && (op == 8'h02 || op == 8'h03)) begin tag = 10; a = fe; end // R10
    else if (kind == 1 && model_last == 4) begin tag = 11; a = fe; end   // R11
    else if (cmpn) begin
      if (dsel == 16'hFFFF)    begin tag = 3; a = cmd; end               // R3
      else if (dsel == page)   begin tag = 4; a = 1;   end               // R4
      else                     begin tag = 5; a = 0;   end               // R5
    end else if (!men)         begin tag = 8; a = cmd; end               // R8
    else if (!man && minn)     begin tag = 6; a = 1;   end               // R6
    else                       begin tag = 7; a = cmd; end               // R7
    exp = a ? (4'b0001 << kind) : 4'b0000;
    if (vld && kind == 0 && a) model_last = int'(op);
    @(negedge clk);
    check(tag, exp);
  endtask

  task automatic drive(input bit v, input int k, input int o, input logic [SW-1:0] s,
                       input bit c, input bit ma, input bit mi, input bit fi, input bit ff,
                       input bit me);
    vld = v; kind = 2'(k); op = 8'(o); dsel = s;
    cmpn = c; man = ma; minn = mi; finn = fi; ffn = ff; men = me;
    step();
  endtask

  task automatic do_reset();
    vld = 0;
    rst_n = 0;
    model_last = 0;
    @(negedge clk);
    check(1, 4'b0000); // R1
    @(negedge clk);
    check(1, 4'b0000); // R1
    rst_n = 1;
  endtask

  initial begin
    rst_n = 0; vld = 0; kind = 0; op = 0; dsel = 0; page = 16'h0123;
    cmpn = 1; man = 1; minn = 1; finn = 1; ffn = 0; men = 1;
    @(negedge clk);
    do_reset();
    // R3 broadcast
    drive(1, 0, 0, 16'hFFFF, 1, 1, 1, 1, 0, 1);
    drive(1, 1, 0, 16'hFFFF, 1, 1, 1, 1, 0, 1);
    drive(1, 3, 0, 16'hFFFF, 1, 1, 1, 1, 0, 1);
    // R4 page hit, all kinds
    for (int k = 0; k < 4; k++) drive(1, k, 0, 16'h0123, 1, 1, 1, 1, 0, 1);
    // R5 miss
    drive(1, 1, 0, 16'h0124, 1, 1, 1, 1, 0, 1);
    drive(1, 2, 0, 16'h0124, 1, 1, 1, 1, 0, 1);
    // R6 priority match
    drive(1, 3, 0, 16'h0124, 0, 0, 1, 1, 0, 1);
    // R7 match-in low, then no local match
    drive(1, 2, 0, 16'h0124, 0, 0, 0, 1, 0, 1);
    drive(1, 1, 0, 16'h0124, 0, 1, 1, 1, 0, 1);
    // R8 flag disabled with local match
    drive(1, 3, 0, 16'h0124, 0, 0, 1, 1, 0, 0);
    drive(1, 0, 0, 16'h0124, 0, 0, 1, 1, 0, 0);
    // R9 load select on a mismatched device
    drive(1, 0, 1, 16'h0999, 1, 1, 1, 1, 0, 1);
    // R10 page load / set full
    drive(1, 0, 2, 16'h0123, 1, 1, 1, 1, 1, 1);
    drive(1, 0, 3, 16'h0123, 1, 1, 1, 0, 0, 1);
    drive(1, 0, 2, 16'h0999, 1, 1, 1, 0, 1, 1);
    // R11 status next-free then reads
    drive(1, 0, 4, 16'hFFFF, 1, 1, 1, 1, 0, 1);
    drive(0, 0, 0, 16'hFFFF, 1, 1, 1, 1, 0, 1);
    drive(1, 1, 0, 16'hFFFF, 1, 1, 1, 1, 0, 1);
    drive(1, 1, 0, 16'hFFFF, 1, 1, 1, 0, 1, 1);
    drive(1, 0, 0, 16'hFFFF, 1, 1, 1, 1, 0, 1);
    drive(1, 1, 0, 16'hFFFF, 1, 1, 1, 1, 0, 1);
    // R1 reset clears history
    drive(1, 0, 4, 16'hFFFF, 1, 1, 1, 1, 0, 1);
    do_reset();
    drive(1, 1, 0, 16'hFFFF, 1, 1, 1, 1, 0, 1);
    // R3 precedence over a page of all ones
    page = 16'hFFFF;
    drive(1, 2, 0, 16'hFFFF, 1, 1, 1, 1, 0, 1);
    drive(1, 3, 0, 16'hFFFF, 1, 1, 1, 1, 0, 1);
    page = 16'h0123;
    // mixed stimulus against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [SW-1:0] s;
      r = int'($urandom_range(0, 3));
      s = (r == 0) ? 16'hFFFF : (r == 1) ? page : 16'($urandom);
      if (i % 500 == 250) begin
        page = 16'($urandom);
        if (i == 1750) page = 16'hFFFF;
      end
      drive(($urandom_range(0, 7) != 0), int'($urandom_range(0, 3)),
            int'($urandom_range(0, 5)), s, 1'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), ($urandom_range(0, 3) != 0));
      if (i % 1300 == 1299) do_reset();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL R2 watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule